// File: doc/BRIEF.md
# Interval Timer Counter Channel

This block is a single channel of a programmable interval timer. Software loads a 16-bit start value through an 8-bit register port, one byte at a time with the low byte first. A control write then starts the channel. While the channel runs and its gate input is high, every cycle in which the count-clock enable is high lowers the value by one. The value is treated either as a plain binary number or as four BCD digits. When the value reaches zero, the block raises a one-cycle terminal pulse that can drive a CPU interrupt line.

There are two pulse-on-zero behaviours. In one-shot operation the channel stops at zero. In auto-reload operation it reloads the stored start value and keeps running, which gives a periodic rate pulse. A latch command freezes a copy of the running value for readback, so software can read a stable snapshot while counting goes on. The read and write byte sequences are tracked separately, so reads and writes to the channel can be interleaved freely.

The data port is selected with `cpu_sel_ctrl` low. The control port is selected with `cpu_sel_ctrl` high. A control write with bit 7 set is a latch command and changes nothing else. A control write with bit 7 clear sets the counting mode and the start/stop state: bit 0 set means BCD and clear means binary; bit 1 set means auto-reload and clear means one-shot; bit 2 set means start and clear means stop. Reads of the control port return zero.

Top module: `interval_timer_channel`

## Requirements
- R1: After a synchronous reset, `term_pulse` and `cpu_rdata` are 0, the channel is stopped, and a two-byte read of the data port returns 0x0000.
- R2: A data-port write stores a low byte when the write pointer is on the low byte, and a high byte otherwise. A stored value only becomes a valid start value after its high byte is written. A start command given before any complete load is ignored, and the channel stays stopped.
- R3: While running, the value decreases by one at each clock edge where both `count_tick` and `gate` are high. If either is low, the value holds.
- R4: In BCD mode (control bit 0 = 1), each 4-bit digit that decrements below 0 wraps to 9 and borrows from the next digit. For example, 0x0100 becomes 0x0099.
- R5: When a tick takes the value from 1 to 0, `term_pulse` is high for exactly the one cycle after that edge.
- R6: In one-shot mode (control bit 1 = 0), the channel stops at zero. Later ticks leave the value at 0x0000 and produce no further pulse.
- R7: In auto-reload mode (control bit 1 = 1), the stored start value is reloaded at the edge that ends the pulse cycle, and a tick at that edge is ignored. A start value of N with a tick on every cycle therefore gives one pulse every N+1 cycles.
- R8: A start value of 0x0000 means the largest count: 65536 ticks to the pulse in binary mode and 10000 ticks in BCD mode.
- R9: A latch command (control bit 7 = 1) copies the current value. The next two data-port reads return that copy, low byte first, even while counting continues. The copy is held until its high byte is read, and a latch command issued while a copy is held is ignored.
- R10: With no copy held, data-port reads return the bytes of the live value, low byte then high byte. The result appears on `cpu_rdata` one cycle after the read strobe.
- R11: The read byte pointer and the write byte pointer advance independently, so a read between the two bytes of a load does not disturb the load.
- R12: A control write with bit 7 clear returns the write pointer to the low byte. When its bit 2 is clear, it stops the channel and the value is frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_sel_ctrl | input | 1 | 1 selects the control port, 0 the data port |
| cpu_wdata | input | 8 | Write data byte |
| cpu_rdata | output | 8 | Registered read data byte |
| count_tick | input | 1 | Count-clock enable, one decrement per high cycle |
| gate | input | 1 | Counting enable |
| term_pulse | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
The assertions assume that a read strobe and a write strobe are never high in the same cycle. They also assume that BCD mode is only run on values whose digits are all 0 to 9. The bench drives every register access as an isolated single-cycle strobe on the falling clock edge, and it loads only valid BCD values before selecting BCD mode. Tick and gate patterns are stepped deliberately, so that held, gated, reloaded and wrapped counts all occur.

// File: rtl/itc_pkg.sv
package itc_pkg;

  // Control byte field positions
  localparam int CTRL_BCD_BIT   = 0;
  localparam int CTRL_AUTO_BIT  = 1;
  localparam int CTRL_START_BIT = 2;
  localparam int CTRL_LATCH_BIT = 7;

  typedef struct packed {
    logic bcd;
    logic auto_rl;
  } itc_mode_t;

endpackage

// File: rtl/itc_decrement.sv
module itc_decrement #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] value_i,
  input  logic             bcd_i,
  output logic [CNT_W-1:0] value_o
);
  localparam int DIGITS = CNT_W / 4;

  logic [DIGITS-1:0] borrow;
  logic [CNT_W-1:0]  bcd_next;
  logic [CNT_W-1:0]  bin_next;

  assign borrow[0] = 1'b1;
  assign bin_next  = value_i - CNT_W'(1);

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    logic [3:0] nib;
    assign nib = value_i[d*4 +: 4];
    assign bcd_next[d*4 +: 4] = !borrow[d]     ? nib :
                                (nib == 4'd0)  ? 4'd9 : nib - 4'd1;
    if (d < DIGITS - 1) begin : g_chain
      assign borrow[d+1] = borrow[d] & (nib == 4'd0);
    end
  end

  assign value_o = bcd_i ? bcd_next : bin_next;

endmodule

// File: rtl/itc_host_regs.sv
module itc_host_regs
  import itc_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_i,
  input  logic               sel_ctrl_i,
  input  logic [BUS_W-1:0]   wdata_i,
  output logic [2*BUS_W-1:0] reload_o,
  output itc_mode_t          mode_o,
  output logic               start_o,
  output logic               stop_o,
  output logic               latch_o
);
  logic [BUS_W-1:0]   lo_q;
  logic [2*BUS_W-1:0] reload_q;
  logic               loaded_q;
  logic               wptr_q;
  itc_mode_t          mode_q;
  logic               ctrl_wr;
  logic               mode_wr;

  assign ctrl_wr = wr_i & sel_ctrl_i;
  assign mode_wr = ctrl_wr & ~wdata_i[CTRL_LATCH_BIT];
  assign latch_o = ctrl_wr &  wdata_i[CTRL_LATCH_BIT];
  assign start_o = mode_wr &  wdata_i[CTRL_START_BIT] & loaded_q;
  assign stop_o  = mode_wr & ~wdata_i[CTRL_START_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q     <= '0;
      reload_q <= '0;
      loaded_q <= 1'b0;
      wptr_q   <= 1'b0;
      mode_q   <= '0;
    end else if (wr_i) begin
      if (sel_ctrl_i) begin
        if (!wdata_i[CTRL_LATCH_BIT]) begin
          mode_q.bcd     <= wdata_i[CTRL_BCD_BIT];
          mode_q.auto_rl <= wdata_i[CTRL_AUTO_BIT];
          wptr_q         <= 1'b0;
        end
      end else if (!wptr_q) begin
        lo_q   <= wdata_i;
        wptr_q <= 1'b1;
      end else begin
        reload_q <= {wdata_i, lo_q};
        loaded_q <= 1'b1;
        wptr_q   <= 1'b0;
      end
    end
  end

  assign reload_o = reload_q;
  assign mode_o   = mode_q;

endmodule

// File: rtl/itc_counter_core.sv
module itc_counter_core
  import itc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] reload_i,
  input  itc_mode_t        mode_i,
  input  logic             tick_i,
  input  logic             gate_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             running_o,
  output logic             term_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_dec;
  logic             running_q;
  logic             term_q;

  itc_decrement #(.CNT_W(CNT_W)) u_dec (
    .value_i (cnt_q),
    .bcd_i   (mode_i.bcd),
    .value_o (cnt_dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      running_q <= 1'b0;
      term_q    <= 1'b0;
    end else begin
      term_q <= 1'b0;
      if (start_i) begin
        cnt_q     <= reload_i;
        running_q <= 1'b1;
      end else if (stop_i) begin
        running_q <= 1'b0;
      end else if (term_q && mode_i.auto_rl && running_q) begin
        cnt_q <= reload_i;
      end else if (running_q && gate_i && tick_i) begin
        if (cnt_q == ONE) begin
          cnt_q  <= '0;
          term_q <= 1'b1;
          if (!mode_i.auto_rl) running_q <= 1'b0;
        end else begin
          cnt_q <= cnt_dec;
        end
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign running_o = running_q;
  assign term_o    = term_q;

endmodule

// File: rtl/itc_readback.sv
module itc_readback #(
  parameter int BUS_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_i,
  input  logic               sel_ctrl_i,
  input  logic               latch_i,
  input  logic [2*BUS_W-1:0] cnt_i,
  output logic [BUS_W-1:0]   rdata_o,
  output logic               latched_o,
  output logic [2*BUS_W-1:0] snap_o
);
  logic [2*BUS_W-1:0] snap_q;
  logic               latched_q;
  logic               rptr_q;
  logic [BUS_W-1:0]   rdata_q;
  logic [2*BUS_W-1:0] src;

  assign src = latched_q ? snap_q : cnt_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q    <= '0;
      latched_q <= 1'b0;
      rptr_q    <= 1'b0;
      rdata_q   <= '0;
    end else begin
      if (latch_i && !latched_q) begin
        snap_q    <= cnt_i;
        latched_q <= 1'b1;
      end
      if (rd_i) begin
        if (sel_ctrl_i) begin
          rdata_q <= '0;
        end else begin
          rdata_q <= rptr_q ? src[2*BUS_W-1:BUS_W] : src[BUS_W-1:0];
          rptr_q  <= ~rptr_q;
          if (rptr_q && latched_q) latched_q <= 1'b0;
        end
      end
    end
  end

  assign rdata_o   = rdata_q;
  assign latched_o = latched_q;
  assign snap_o    = snap_q;

endmodule

// File: rtl/interval_timer_channel.sv
module interval_timer_channel
  import itc_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_wr,
  input  logic             cpu_rd,
  input  logic             cpu_sel_ctrl,
  input  logic [BUS_W-1:0] cpu_wdata,
  output logic [BUS_W-1:0] cpu_rdata,
  input  logic             count_tick,
  input  logic             gate,
  output logic             term_pulse
);
  localparam int CNT_W = 2 * BUS_W;

  logic [CNT_W-1:0] reload_w;
  itc_mode_t        mode_w;
  logic             start_w;
  logic             stop_w;
  logic             latch_w;
  logic [CNT_W-1:0] cnt_w;
  logic             running_w;
  logic             latched_w;
  logic [CNT_W-1:0] snap_w;

  itc_host_regs #(.BUS_W(BUS_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_i       (cpu_wr),
    .sel_ctrl_i (cpu_sel_ctrl),
    .wdata_i    (cpu_wdata),
    .reload_o   (reload_w),
    .mode_o     (mode_w),
    .start_o    (start_w),
    .stop_o     (stop_w),
    .latch_o    (latch_w)
  );

  itc_counter_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_w),
    .stop_i    (stop_w),
    .reload_i  (reload_w),
    .mode_i    (mode_w),
    .tick_i    (count_tick),
    .gate_i    (gate),
    .cnt_o     (cnt_w),
    .running_o (running_w),
    .term_o    (term_pulse)
  );

  itc_readback #(.BUS_W(BUS_W)) u_rb (
    .clk        (clk),
    .rst        (rst),
    .rd_i       (cpu_rd),
    .sel_ctrl_i (cpu_sel_ctrl),
    .latch_i    (latch_w),
    .cnt_i      (cnt_w),
    .rdata_o    (cpu_rdata),
    .latched_o  (latched_w),
    .snap_o     (snap_w)
  );

endmodule

// File: rtl/itc_checker.sv
module itc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cpu_wr,
  input logic             cpu_rd,
  input logic             cpu_sel_ctrl,
  input logic             count_tick,
  input logic             gate,
  input logic             term_pulse,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload,
  input logic             running,
  input logic             auto_rl,
  input logic             bcd,
  input logic             latched,
  input logic [CNT_W-1:0] snap
);
  function automatic logic digits_ok(input logic [CNT_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < CNT_W / 4; i++) begin
      if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    term_pulse |=> !term_pulse); // R5

  AST_PULSE_FROM_ONE: assert property (@(posedge clk) disable iff (rst)
    term_pulse |-> ($past(cnt) == CNT_W'(1)) && $past(count_tick && gate && running)); // R5

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (!count_tick || !gate) && !(cpu_wr && cpu_sel_ctrl) && !term_pulse |=> $stable(cnt)); // R3

  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (rst)
    term_pulse && !auto_rl |-> !running); // R6

  AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (rst)
    term_pulse && auto_rl && running && !(cpu_wr && cpu_sel_ctrl) |=> cnt == $past(reload)); // R7

  AST_BCD_DIGITS: assert property (@(posedge clk) disable iff (rst)
    bcd && running && gate && count_tick && !cpu_wr && !term_pulse && digits_ok(cnt)
    |=> digits_ok(cnt)); // R4

  AST_SNAP_HELD: assert property (@(posedge clk) disable iff (rst)
    latched && !(cpu_rd && !cpu_sel_ctrl) |=> latched && $stable(snap)); // R9

  AST_STROBES_APART: assert property (@(posedge clk) disable iff (rst)
    !(cpu_rd && cpu_wr)); // R11

endmodule

bind interval_timer_channel itc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cpu_wr       (cpu_wr),
  .cpu_rd       (cpu_rd),
  .cpu_sel_ctrl (cpu_sel_ctrl),
  .count_tick   (count_tick),
  .gate         (gate),
  .term_pulse   (term_pulse),
  .cnt          (cnt_w),
  .reload       (reload_w),
  .running      (running_w),
  .auto_rl      (mode_w.auto_rl),
  .bcd          (mode_w.bcd),
  .latched      (latched_w),
  .snap         (snap_w)
);

// File: tb/interval_timer_channel_tb.sv
module interval_timer_channel_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_wr = 1'b0;
  logic       cpu_rd = 1'b0;
  logic       cpu_sel_ctrl = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic       count_tick = 1'b0;
  logic       gate = 1'b1;
  logic       term_pulse;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  interval_timer_channel u_dut (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_sel_ctrl(cpu_sel_ctrl), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .count_tick(count_tick), .gate(gate), .term_pulse(term_pulse)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_cnt, m_run, m_term, m_creg, m_lo, m_loaded, m_wptr;
  int m_bcd, m_auto, m_snap, m_latched, m_rptr, m_rdata;

  function automatic int dec_val(input int v, input int is_bcd);
    int d;
    if (!is_bcd) return (v + 65535) % 65536;
    d = ((v >> 12) & 15) * 1000 + ((v >> 8) & 15) * 100 + ((v >> 4) & 15) * 10 + (v & 15);
    d = (d + 9999) % 10000;
    return ((d / 1000) << 12) | (((d / 100) % 10) << 8) | (((d / 10) % 10) << 4) | (d % 10);
  endfunction

  always @(posedge clk) begin
    int old_cnt, src, nterm;
    bit start, stop;
    if (rst) begin
      m_cnt = 0; m_run = 0; m_term = 0; m_creg = 0; m_lo = 0; m_loaded = 0; m_wptr = 0;
      m_bcd = 0; m_auto = 0; m_snap = 0; m_latched = 0; m_rptr = 0; m_rdata = 0;
    end else begin
      old_cnt = m_cnt;
      if (cpu_rd) begin
        if (cpu_sel_ctrl) m_rdata = 0;
        else begin
          src = m_latched ? m_snap : old_cnt;
          m_rdata = m_rptr ? (src >> 8) & 255 : src & 255;
          if (m_rptr && m_latched) m_latched = 0;
          m_rptr = 1 - m_rptr;
        end
      end
      if (cpu_wr && cpu_sel_ctrl && cpu_wdata[7] && !m_latched) begin
        m_snap = old_cnt; m_latched = 1;
      end
      start = cpu_wr && cpu_sel_ctrl && !cpu_wdata[7] && cpu_wdata[2] && m_loaded != 0;
      stop  = cpu_wr && cpu_sel_ctrl && !cpu_wdata[7] && !cpu_wdata[2];
      nterm = 0;
      if (start) begin m_cnt = m_creg; m_run = 1; end
      else if (stop) m_run = 0;
      else if (m_term != 0 && m_auto != 0 && m_run != 0) m_cnt = m_creg;
      else if (m_run != 0 && gate && count_tick) begin
        if (m_cnt == 1) begin
          m_cnt = 0; nterm = 1;
          if (!m_auto) m_run = 0;
        end else m_cnt = dec_val(m_cnt, m_bcd);
      end
      m_term = nterm;
      if (cpu_wr) begin
        if (cpu_sel_ctrl) begin
          if (!cpu_wdata[7]) begin
            m_bcd = int'(cpu_wdata[0]); m_auto = int'(cpu_wdata[1]); m_wptr = 0;
          end
        end else if (m_wptr == 0) begin
          m_lo = int'(cpu_wdata); m_wptr = 1;
        end else begin
          m_creg = int'(cpu_wdata) * 256 + m_lo; m_loaded = 1; m_wptr = 0;
        end
      end
    end
  end

  // Compare with the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R5 term_pulse vs model", int'(term_pulse), m_term);
      check("R9/R10 cpu_rdata vs model", int'(cpu_rdata), m_rdata);
    end
  end

  task automatic wr(input logic ctrl, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_sel_ctrl = ctrl; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_sel_ctrl = 1'b0;
  endtask

  task automatic rd_byte(output int b);
    @(negedge clk);
    cpu_rd = 1'b1; cpu_sel_ctrl = 1'b0;
    @(negedge clk);
    cpu_rd = 1'b0;
    b = int'(cpu_rdata);
  endtask

  task automatic rd_word(output int w);
    int lo, hi;
    rd_byte(lo);
    rd_byte(hi);
    w = hi * 256 + lo;
  endtask

  task automatic load(input int v);
    wr(1'b0, 8'(v & 255));
    wr(1'b0, 8'((v >> 8) & 255));
  endtask

  task automatic ticks(input int k);
    @(negedge clk);
    count_tick = 1'b1;
    repeat (k) @(negedge clk);
    count_tick = 1'b0;
  endtask

  task automatic ticks_to_pulse(input int cap, output int n);
    @(negedge clk);
    count_tick = 1'b1;
    n = 0;
    while (n < cap) begin
      @(negedge clk);
      n++;
      if (term_pulse) break;
    end
    count_tick = 1'b0;
  endtask

  initial begin
    int v, n, b, pulses;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 term_pulse after reset", int'(term_pulse), 0);
    check("R1 rdata after reset", int'(cpu_rdata), 0);
    rd_word(v);
    check("R1 count after reset", v, 0);

    // start before any load is ignored
    wr(1'b1, 8'h04);
    ticks(3);
    rd_word(v);
    check("R2 start without load ignored", v, 0);

    // binary one-shot from 5
    load(5);
    wr(1'b1, 8'h04);
    ticks_to_pulse(100, n);
    check("R5 pulse after five ticks (R3)", n, 5);
    @(negedge clk);
    check("R5 pulse lasts one cycle", int'(term_pulse), 0);
    pulses = 0;
    @(negedge clk);
    count_tick = 1'b1;
    repeat (10) begin
      @(negedge clk);
      if (term_pulse) pulses++;
    end
    count_tick = 1'b0;
    check("R6 no pulse after stop at zero", pulses, 0);
    rd_word(v);
    check("R6 value stays zero", v, 0);

    // gate holds the value
    load(16'h0010);
    wr(1'b1, 8'h04);
    ticks(4);
    gate = 1'b0;
    ticks(5);
    gate = 1'b1;
    rd_word(v);
    check("R3 gated ticks hold value", v, 16'h000C);

    // latch readback
    wr(1'b1, 8'h80);
    ticks(3);
    wr(1'b1, 8'h80);
    ticks(2);
    rd_word(v);
    check("R9 latched copy held", v, 16'h000C);
    rd_word(v);
    check("R10 live value after copy read", v, 16'h0007);

    // interleaved reads and writes
    wr(1'b1, 8'h80);
    wr(1'b0, 8'h34);
    rd_byte(b);
    check("R11 latched low byte mid-load", b, 16'h07);
    wr(1'b0, 8'h12);
    rd_byte(b);
    check("R11 latched high byte mid-load", b, 0);
    wr(1'b1, 8'h04);
    rd_word(v);
    check("R11 load intact after interleave (R2)", v, 16'h1234);

    // control write resets write pointer and stops
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h00);
    load(16'h0022);
    wr(1'b1, 8'h04);
    ticks(2);
    wr(1'b1, 8'h00);
    ticks(3);
    rd_word(v);
    check("R12 pointer reset and stop freezes", v, 16'h0020);

    // BCD decrement
    load(16'h0100);
    wr(1'b1, 8'h05);
    ticks(1);
    rd_word(v);
    check("R4 bcd 0100 minus one", v, 16'h0099);
    load(16'h1000);
    wr(1'b1, 8'h05);
    ticks(3);
    rd_word(v);
    check("R4 bcd 1000 minus three", v, 16'h0997);

    // auto-reload period
    load(3);
    wr(1'b1, 8'h06);
    ticks_to_pulse(100, n);
    check("R7 first pulse after three ticks", n, 3);
    @(negedge clk);
    count_tick = 1'b1;
    n = 1;
    while (n < 100 && !term_pulse) begin
      @(negedge clk);
      n++;
    end
    count_tick = 1'b0;
    check("R7 reload period", n, 4);
    wr(1'b1, 8'h00);

    // maximum count
    load(0);
    wr(1'b1, 8'h04);
    ticks_to_pulse(70000, n);
    check("R8 binary zero load is 65536", n, 65536);
    load(0);
    wr(1'b1, 8'h05);
    ticks_to_pulse(20000, n);
    check("R8 bcd zero load is 10000", n, 10000);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R5 watchdog expired: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule